// File: doc/BRIEF.md
# Programmable Timebase with Interval Interrupt and Slow-Clock Watchdog

This block runs on a fixed 100 MHz reference clock and produces three things. The first is an internal sample clock. Its period is picked by a 5-bit timebase code from a 1-2-5 ladder that runs from 20 ns to 500 ms. The second is a periodic interrupt request to a microprocessor. The request is raised once per programmable interval and held until the processor performs a status read. The third is a flag that warns when an externally supplied sample clock has stopped or has become too slow. That check is only made while external sample clock mode is selected.

The processor programs all three functions through a single configuration write. The write is applied at the next clock edge. A timebase change does not act at once. It waits for the end of the output period that is in progress, so the output never carries a shortened pulse. The external clock is brought into the reference domain through two flops. A counter then measures the time since its last rising edge against a threshold. The default threshold is 2,500,000 reference cycles, which is 25 ms.

Top module: `tbase_gen`

## Requirements
- R1: While `rst` is high, `sclk_out`, `irq` and `slow_clk` are all held low at each clock edge.
- R2: Timebase code i (0 to 22, in `cfg_data[4:0]`) gives an output period of m·10^floor(i/3) reference cycles. Here m is 2, 5 or 10 for i mod 3 equal to 0, 1 or 2.
- R3: In each output period of P cycles, `sclk_out` is high for the first floor(P/2) cycles and low for the rest.
- R4: Codes 23 to 31 select the shortest period of 2 cycles.
- R5: A new timebase code takes effect only after the current output period ends. The period in progress keeps its old high and low lengths.
- R6: The interval timer flags an elapse every TMR_BASE·2^k reference cycles, where k is `cfg_data[7:5]`. When `irq` is cleared after each rise, the rises of `irq` are exactly that far apart.
- R7: A status read (`sts_rd` high for one cycle) clears a pending `irq` at the next edge, unless an interval elapses in that same cycle.
- R8: While a request is pending and no status read occurs, `irq` stays high across further elapsed intervals and does not toggle.
- R9: When an interval elapses in the same cycle as a status read, `irq` stays high.
- R10: With external mode on (`cfg_data[8]` = 1), `slow_clk` rises when SLOW_LIMIT cycles pass after a detected rising edge of `ext_clk` with no new edge. Edge gaps of SLOW_LIMIT cycles or less never raise it.
- R11: A detected rising edge of `ext_clk` clears `slow_clk`.
- R12: With external mode off, `slow_clk` is low whatever `ext_clk` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | 100 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_data | input | 9 | [4:0] timebase code, [7:5] interval exponent, [8] external mode |
| sts_rd | input | 1 | Status read strobe, clears the interrupt request |
| ext_clk | input | 1 | External sample clock, asynchronous |
| sclk_out | output | 1 | Generated internal sample clock |
| irq | output | 1 | Interval interrupt request |
| slow_clk | output | 1 | External clock too slow or stopped |

## Verification
Two events can land on the same reference cycle: an interval elapse that sets the request, and a status read that clears it. The bench holds the interval exponent fixed and counts cycles from an observed rise of `irq`. It then places the read strobe on the exact edge where the next elapse occurs, and `irq` must still be high after that edge. A second read one cycle later, with no elapse, must bring it low. The watchdog boundary is also probed. Edge gaps of exactly SLOW_LIMIT cycles must never raise the flag, while gaps one cycle longer must raise it for exactly one cycle per gap.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

    localparam int SEL_W     = 5;
    localparam int IVL_W     = 3;
    localparam int CFG_W     = SEL_W + IVL_W + 1;
    localparam int NUM_CODES = 23;
    localparam int PER_W     = 26;
    localparam int MAX_DEC   = 8;

    typedef struct packed {
        logic [SEL_W-1:0] tb_sel;
        logic [IVL_W-1:0] iv_sel;
        logic             ext_mode;
    } cfg_t;

    typedef struct packed {
        logic [PER_W-1:0] cnt;
        logic [PER_W-1:0] per;
        logic             out;
    } div_st_t;

    // Period in reference cycles for a timebase code (1-2-5 ladder from 2 cycles).
    function automatic logic [PER_W-1:0] code_period(input logic [SEL_W-1:0] code);
        logic [PER_W-1:0] p;
        int c;
        int dec;
        c = int'(code);
        if (c >= NUM_CODES) begin
            p = PER_W'(2);
        end else begin
            case (c % 3)
                0:       p = PER_W'(2);
                1:       p = PER_W'(5);
                default: p = PER_W'(10);
            endcase
            dec = c / 3;
            for (int k = 0; k < MAX_DEC; k++) begin
                if (k < dec) p = p * PER_W'(10);
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/tbase_div.sv
module tbase_div
    import tbase_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    output logic             sclk
);

    div_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == st_q.per - 1'b1) begin
            st_d.cnt = '0;
            st_d.per = code_period(sel);
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.out = (st_d.cnt < (st_d.per >> 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt <= '0;
            st_q.per <= code_period('0);
            st_q.out <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk = st_q.out;

    // Counter never leaves the active period window
    assert_cnt_in_period_R2: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt < st_q.per);

    // Period register may only change where the previous period ended
    assert_switch_at_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (st_q.per != $past(st_q.per)) |-> ($past(st_q.cnt) == $past(st_q.per) - 1'b1));

endmodule

// File: rtl/tbase_timer.sv
module tbase_timer
    import tbase_pkg::*;
#(
    parameter int BASE = 100000,
    parameter int CW   = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IVL_W-1:0] iv_sel,
    input  logic             sts_rd,
    output logic             irq
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          irq;
    } tmr_st_t;

    tmr_st_t       st_q, st_d;
    logic [CW-1:0] ivl;
    logic          tc;

    always_comb begin
        ivl  = CW'(BASE) << iv_sel;
        tc   = (st_q.cnt >= ivl - 1'b1);
        st_d = st_q;
        st_d.cnt = tc ? '0 : st_q.cnt + 1'b1;
        st_d.irq = tc | (st_q.irq & ~sts_rd);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign irq = st_q.irq;

    assert_rise_on_elapse_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.irq) |-> ($past(st_q.cnt) >= $past(ivl) - 1'b1));

    assert_fall_needs_read_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(st_q.irq) |-> $past(sts_rd));

    assert_pending_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q.irq && !sts_rd) |=> st_q.irq);

    assert_elapse_beats_read_R9: assert property (@(posedge clk) disable iff (rst)
        (sts_rd && (st_q.cnt >= ivl - 1'b1)) |=> st_q.irq);

endmodule

// File: rtl/tbase_slowdet.sv
module tbase_slowdet #(
    parameter int LIMIT = 2500000
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_mode,
    input  logic ext_clk,
    output logic slow
);

    localparam int CW = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [2:0]    sync;
        logic [CW-1:0] cnt;
        logic          slow;
    } wd_st_t;

    wd_st_t st_q, st_d;
    logic   rise;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[1:0], ext_clk};
        rise      = st_q.sync[1] & ~st_q.sync[2];
        if (!ext_mode || rise) begin
            st_d.cnt  = '0;
            st_d.slow = 1'b0;
        end else begin
            if (st_q.cnt != CW'(LIMIT)) st_d.cnt = st_q.cnt + 1'b1;
            if (st_d.cnt == CW'(LIMIT)) st_d.slow = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign slow = st_q.slow;

    assert_flag_after_limit_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.slow) |-> ($past(st_q.cnt) == CW'(LIMIT - 1)));

    assert_edge_clears_R11: assert property (@(posedge clk) disable iff (rst)
        rise |=> !st_q.slow);

    assert_internal_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        !ext_mode |=> !st_q.slow);

endmodule

// File: rtl/tbase_gen.sv
module tbase_gen
    import tbase_pkg::*;
#(
    parameter int TMR_BASE   = 100000,
    parameter int TMR_W      = 32,
    parameter int SLOW_LIMIT = 2500000
) (
    input  logic             clk_ref,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic             sts_rd,
    input  logic             ext_clk,
    output logic             sclk_out,
    output logic             irq,
    output logic             slow_clk
);

    cfg_t cfg_q, cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            cfg_d.tb_sel   = cfg_data[SEL_W-1:0];
            cfg_d.iv_sel   = cfg_data[SEL_W+IVL_W-1:SEL_W];
            cfg_d.ext_mode = cfg_data[CFG_W-1];
        end
    end

    always_ff @(posedge clk_ref) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_d;
    end

    tbase_div u_div (
        .clk  (clk_ref),
        .rst  (rst),
        .sel  (cfg_q.tb_sel),
        .sclk (sclk_out)
    );

    tbase_timer #(.BASE(TMR_BASE), .CW(TMR_W)) u_tmr (
        .clk    (clk_ref),
        .rst    (rst),
        .iv_sel (cfg_q.iv_sel),
        .sts_rd (sts_rd),
        .irq    (irq)
    );

    tbase_slowdet #(.LIMIT(SLOW_LIMIT)) u_wd (
        .clk      (clk_ref),
        .rst      (rst),
        .ext_mode (cfg_q.ext_mode),
        .ext_clk  (ext_clk),
        .slow     (slow_clk)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk_ref)
        rst |=> (!sclk_out && !irq && !slow_clk));

endmodule

// File: tb/sim_tbase_gen.sv
`timescale 1ns/1ps
module sim_tbase_gen;

    localparam int TB_TMR = 16;
    localparam int TB_LIM = 200;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [8:0] cfg_data = '0;
    logic       sts_rd = 1'b0;
    logic       ext_clk = 1'b0;
    logic       sclk_out, irq, slow_clk;

    int checks = 0;
    int fails  = 0;
    int slow_hi = 0;

    always #4 clk = ~clk;

    tbase_gen #(.TMR_BASE(TB_TMR), .SLOW_LIMIT(TB_LIM)) u0 (
        .clk_ref(clk), .rst(rst), .cfg_we(cfg_we), .cfg_data(cfg_data),
        .sts_rd(sts_rd), .ext_clk(ext_clk),
        .sclk_out(sclk_out), .irq(irq), .slow_clk(slow_clk)
    );

    always @(negedge clk) slow_hi <= slow_hi + int'(slow_clk);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic ext, input int isel, input int code);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_data = {ext, 3'(isel), 5'(code)};
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    function automatic int exp_period(input int code);
        int p;
        if (code > 22) return 2;
        p = (code % 3 == 0) ? 2 : (code % 3 == 1) ? 5 : 10;
        for (int k = 0; k < code / 3; k++) p = p * 10;
        return p;
    endfunction

    // Leaves the bench on the first negedge where sclk_out is seen high after low
    task automatic sync_rise();
        while (sclk_out) @(negedge clk);
        while (!sclk_out) @(negedge clk);
    endtask

    // Starts at a rise sample, ends at the next rise sample
    task automatic meas(output int hi, output int lo);
        hi = 0; lo = 0;
        while (sclk_out) begin hi++; @(negedge clk); end
        while (!sclk_out) begin lo++; @(negedge clk); end
    endtask

    // Starts with irq high; reads it away, counts cycles to the next rise
    task automatic irq_interval(output int n);
        sts_rd = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            sts_rd = 1'b0;
            n++;
        end while (!irq);
    endtask

    task automatic ext_train(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            ext_clk = 1'b1;
            for (int j = 0; j < gap; j++) begin
                @(negedge clk);
                if (j == 1) ext_clk = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int hi, lo, n, base, lows;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 sclk_out in reset", int'(sclk_out), 0);
        chk("R1 irq in reset", int'(irq), 0);
        chk("R1 slow_clk in reset", int'(slow_clk), 0);
        rst = 1'b0;

        // R2/R3: sweep of the short codes
        for (int code = 0; code <= 8; code++) begin
            cfg_write(1'b0, 0, code);
            sync_rise();
            meas(hi, lo);
            meas(hi, lo);
            chk($sformatf("R2 period code %0d", code), hi + lo, exp_period(code));
            chk($sformatf("R3 high time code %0d", code), hi, exp_period(code) / 2);
        end

        // R4: unused codes fall back to 2 cycles
        for (int code = 23; code <= 31; code += 4) begin
            cfg_write(1'b0, 0, code);
            sync_rise();
            meas(hi, lo);
            meas(hi, lo);
            chk($sformatf("R4 period code %0d", code), hi + lo, 2);
        end

        // R5: switching from 1000-cycle period to code 0 mid-period
        cfg_write(1'b0, 0, 8);
        sync_rise();
        meas(hi, lo);
        cfg_we   = 1'b1;
        cfg_data = {1'b0, 3'd0, 5'd0};
        hi = 0; lo = 0;
        while (sclk_out) begin hi++; @(negedge clk); cfg_we = 1'b0; end
        while (!sclk_out) begin lo++; @(negedge clk); end
        chk("R5 old high phase kept", hi, 500);
        chk("R5 old low phase kept", lo, 500);
        meas(hi, lo);
        chk("R5 new period after wrap", hi + lo, 2);

        // R6: interval sweep over all exponents
        for (int k = 0; k < 8; k++) begin
            cfg_write(1'b0, k, 0);
            while (!irq) @(negedge clk);
            irq_interval(n);
            irq_interval(n);
            chk($sformatf("R6 interval exp %0d", k), n, TB_TMR << k);
        end

        // R8, R9, R7 with interval 16
        cfg_write(1'b0, 0, 0);
        while (!irq) @(negedge clk);
        irq_interval(n);
        irq_interval(n);
        lows = 0;
        repeat (3 * TB_TMR) begin @(negedge clk); lows += int'(!irq); end
        chk("R8 pending irq never dropped", lows, 0);
        repeat (TB_TMR - 1) @(negedge clk);
        sts_rd = 1'b1;
        @(negedge clk);
        sts_rd = 1'b0;
        chk("R9 elapse with read keeps irq", int'(irq), 1);
        sts_rd = 1'b1;
        @(negedge clk);
        sts_rd = 1'b0;
        chk("R7 read clears irq", int'(irq), 0);

        // R10: boundary of the watchdog
        cfg_write(1'b1, 0, 0);
        base = slow_hi;
        ext_train(5, TB_LIM);
        chk("R10 gap equal to limit", slow_hi - base, 0);
        cfg_write(1'b0, 0, 0);
        cfg_write(1'b1, 0, 0);
        base = slow_hi;
        ext_train(5, TB_LIM + 1);
        chk("R10 gap one over limit", slow_hi - base, 4);
        repeat (TB_LIM + 5) @(negedge clk);
        chk("R10 stalled clock flagged", int'(slow_clk), 1);

        // R11: an edge clears the flag
        ext_clk = 1'b1;
        repeat (4) @(negedge clk);
        chk("R11 edge clears flag", int'(slow_clk), 0);
        ext_clk = 1'b0;

        // R12: internal mode suppresses the flag
        repeat (TB_LIM + 5) @(negedge clk);
        chk("R12 precondition flag set", int'(slow_clk), 1);
        cfg_write(1'b0, 0, 0);
        repeat (3) @(negedge clk);
        chk("R12 flag drops in internal mode", int'(slow_clk), 0);
        repeat (TB_LIM + 10) @(negedge clk);
        chk("R12 flag stays low in internal mode", int'(slow_clk), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule